// File: doc/BRIEF.md
# Debug Port Protocol Switch Monitor

This block watches the combined mode/data line of a two-protocol debug port from the target side. It samples the line on every rising edge of the debug clock and keeps track of which protocol is active: the four-wire boundary-scan protocol (JTAG) or the two-wire serial protocol. The port comes out of power-on reset in JTAG mode. A switch command is honoured only when it comes straight after a long run of high samples, because such a run puts both protocols into a known reset state.

A run of `RUN_LEN` high samples arms the detector. The first low sample after that opens a 16-sample window, and the window is compared with two fixed codes. One code selects serial-wire mode and the other selects JTAG mode. The block pulses a flag when the mode changes. It raises a line-reset flag when a long high run is seen in serial-wire mode. It also shadows the JTAG TAP state machine, which walks through a fixed loop of states as the serial-wire command bits are shifted in.

Top module: `swj_mode_watch`

## Requirements
- R1: While `rst_n` is low, and until the first sampling edge after it goes high, `swd_mode`, `mode_changed` and `line_reset` are 0 and `tap_state` is 0 (Test-Logic-Reset).
- R2: The detector arms only after at least `RUN_LEN` (default 50) consecutive high samples. A command that follows a run of 49 highs is ignored, and one that follows a run of 50 or more is honoured.
- R3: A low sample resets the count of consecutive highs to zero. Two partial runs split by one low do not arm the detector, and `line_reset` is 0 after any low sample.
- R4: Once armed, the detector opens its window at the first low sample. If those 16 samples, least significant bit first, equal 0xE79E, `swd_mode` becomes 1 on the edge that samples the 16th bit.
- R5: A window that differs from both codes disarms the detector. A correct command that follows it without a new run of `RUN_LEN` highs is ignored.
- R6: An armed window equal to 0xE73C, least significant bit first, sets `swd_mode` to 0.
- R7: A command that selects the mode already active leaves `swd_mode` unchanged, and `mode_changed` does not pulse.
- R8: `mode_changed` is 1 for exactly the one cycle that follows the edge on which `swd_mode` changes, and it is 0 at all other times.
- R9: `line_reset` is 1 exactly when `swd_mode` is 1 and the last `RUN_LEN` or more samples were all high. It stays 0 in JTAG mode.
- R10: The count of consecutive highs saturates, so a run of 1000 highs in serial-wire mode keeps `line_reset` at 1.
- R11: In JTAG mode, `tap_state` follows the standard TAP transitions on each sample. The encoding is TLR=0, RTI=1, SelDR=2, CapDR=3, ShDR=4, Ex1DR=5, PauseDR=6, Ex2DR=7, UpdDR=8, SelIR=9, CapIR=10, ShIR=11, Ex1IR=12, PauseIR=13, Ex2IR=14, UpdIR=15. Starting from TLR, the bits of 0xE79E give the trace 1,2,9,0,0,1,1,2,9,0,0,1,1,2,9,0.
- R12: While `swd_mode` is 1, `tap_state` is held at 0 (TLR).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Shared mode-select / serial data line |
| swd_mode | output | 1 | 1 in serial-wire mode, 0 in JTAG mode |
| mode_changed | output | 1 | One-cycle pulse after a mode change |
| line_reset | output | 1 | Serial-wire line reset in progress |
| tap_state | output | 4 | Shadow TAP controller state |

## Verification
The hardest case to reach from the ports is the disarmed state: a near-miss window must leave the detector ignoring a perfectly formed command until a fresh run of highs arrives. The stimulus reaches it by sweeping a single-bit corruption across the window and sending the correct code straight afterwards. A second sweep varies the arming run length from 45 to 55 around the threshold. At the threshold it also follows the shadow TAP state bit by bit while the command is shifted in.

// File: rtl/swj_mode_watch.sv
module swj_mode_watch #(
  parameter int                RUN_LEN  = 50,
  parameter int                CMD_W    = 16,
  parameter logic [CMD_W-1:0]  SWD_CODE = 16'hE79E,
  parameter logic [CMD_W-1:0]  JTG_CODE = 16'hE73C
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output logic       swd_mode,
  output logic       mode_changed,
  output logic       line_reset,
  output logic [3:0] tap_state
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam int BW = $clog2(CMD_W);

  typedef enum logic [1:0] {DET_IDLE, DET_ARMED, DET_SHIFT} det_e;
  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UP_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UP_IR
  } tap_e;

  logic [CW-1:0]    run_q, run_d;
  det_e             det_q, det_d;
  logic [CMD_W-2:0] shreg_q;
  logic [BW-1:0]    nbit_q, nbit_d;
  logic [CMD_W-1:0] word;
  logic             done, hit_swd, hit_jtg;
  logic             swd_q, swd_d, chg_q;
  tap_e             tap_q, tap_d, tap_walk;

  assign run_d   = !tms ? '0 : (run_q == CW'(RUN_LEN)) ? run_q : run_q + CW'(1);
  assign word    = {tms, shreg_q};
  assign done    = (det_q == DET_SHIFT) && (nbit_q == BW'(CMD_W - 1));
  assign hit_swd = done && (word == SWD_CODE);
  assign hit_jtg = done && (word == JTG_CODE);
  assign swd_d   = hit_swd ? 1'b1 : hit_jtg ? 1'b0 : swd_q;

  always_comb begin
    det_d  = det_q;
    nbit_d = nbit_q;
    case (det_q)
      DET_IDLE:  if (run_d == CW'(RUN_LEN)) det_d = DET_ARMED;
      DET_ARMED: if (!tms) begin
                   det_d  = DET_SHIFT;
                   nbit_d = BW'(1);
                 end
      default:   if (done) det_d = DET_IDLE;
                 else      nbit_d = nbit_q + BW'(1);
    endcase
  end

  always_comb begin
    case (tap_q)
      TLR:     tap_walk = tms ? TLR    : RTI;
      RTI:     tap_walk = tms ? SEL_DR : RTI;
      SEL_DR:  tap_walk = tms ? SEL_IR : CAP_DR;
      CAP_DR:  tap_walk = tms ? EX1_DR : SH_DR;
      SH_DR:   tap_walk = tms ? EX1_DR : SH_DR;
      EX1_DR:  tap_walk = tms ? UP_DR  : PA_DR;
      PA_DR:   tap_walk = tms ? EX2_DR : PA_DR;
      EX2_DR:  tap_walk = tms ? UP_DR  : SH_DR;
      UP_DR:   tap_walk = tms ? SEL_DR : RTI;
      SEL_IR:  tap_walk = tms ? TLR    : CAP_IR;
      CAP_IR:  tap_walk = tms ? EX1_IR : SH_IR;
      SH_IR:   tap_walk = tms ? EX1_IR : SH_IR;
      EX1_IR:  tap_walk = tms ? UP_IR  : PA_IR;
      PA_IR:   tap_walk = tms ? EX2_IR : PA_IR;
      EX2_IR:  tap_walk = tms ? UP_IR  : SH_IR;
      default: tap_walk = tms ? SEL_DR : RTI;
    endcase
    tap_d = swd_q ? TLR : tap_walk;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      det_q   <= DET_IDLE;
      nbit_q  <= '0;
      shreg_q <= '0;
      swd_q   <= 1'b0;
      chg_q   <= 1'b0;
      tap_q   <= TLR;
    end else begin
      run_q   <= run_d;
      det_q   <= det_d;
      nbit_q  <= nbit_d;
      shreg_q <= word[CMD_W-1:1];
      swd_q   <= swd_d;
      chg_q   <= swd_d != swd_q;
      tap_q   <= tap_d;
    end
  end

  assign swd_mode     = swd_q;
  assign mode_changed = chg_q;
  assign line_reset   = swd_q && (run_q == CW'(RUN_LEN));
  assign tap_state    = tap_q;
endmodule

// File: rtl/swj_mode_watch_chk.sv
module swj_mode_watch_chk (
  input logic       tck,
  input logic       rst_n,
  input logic       tms,
  input logic       swd_mode,
  input logic       mode_changed,
  input logic       line_reset,
  input logic [3:0] tap_state
);
  assert_pulse_on_change_R8: assert property (@(posedge tck) disable iff (!rst_n)
    mode_changed |-> (swd_mode != $past(swd_mode)));
  assert_change_is_pulsed_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (swd_mode != $past(swd_mode)) |-> mode_changed);
  assert_pulse_single_R8: assert property (@(posedge tck) disable iff (!rst_n)
    mode_changed |=> !mode_changed);
  assert_line_reset_needs_swd_R9: assert property (@(posedge tck) disable iff (!rst_n)
    line_reset |-> swd_mode);
  assert_low_clears_run_R3: assert property (@(posedge tck) disable iff (!rst_n)
    !tms |=> !line_reset);
  assert_tap_held_R12: assert property (@(posedge tck) disable iff (!rst_n)
    swd_mode |-> (tap_state == 4'd0));
endmodule

bind swj_mode_watch swj_mode_watch_chk u_chk (.*);

// File: tb/swj_mode_watch_bench.sv
module swj_mode_watch_bench;
  localparam logic [15:0] SWD = 16'hE79E;
  localparam logic [15:0] JTG = 16'hE73C;

  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       tms = 1'b1;
  logic       swd_mode, mode_changed, line_reset;
  logic [3:0] tap_state;
  int         n_checks = 0;
  int         n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [3:0] trace [16] = '{4'd1, 4'd2, 4'd9, 4'd0, 4'd0, 4'd1, 4'd1, 4'd2,
                             4'd9, 4'd0, 4'd0, 4'd1, 4'd1, 4'd2, 4'd9, 4'd0};

  swj_mode_watch u_swj_mode_watch (.tck, .rst_n, .tms, .swd_mode,
                                   .mode_changed, .line_reset, .tap_state);

  always #5 tck = ~tck;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic b);
    tms = b;
    @(posedge tck);
    #1;
  endtask

  task automatic ones(input int n);
    repeat (n) send(1'b1);
  endtask

  task automatic word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) send(w[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tms = 1'b1;
    repeat (3) @(posedge tck);
    #1;
    rst_n = 1'b1;
  endtask

  function automatic logic rnd_bit();
    logic b;
    b = lfsr[0];
    lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    return b;
  endfunction

  function automatic logic [3:0] tap_next(input logic [3:0] s, input logic b);
    case (s)
      4'd0:  return b ? 4'd0  : 4'd1;
      4'd1:  return b ? 4'd2  : 4'd1;
      4'd2:  return b ? 4'd9  : 4'd3;
      4'd3:  return b ? 4'd5  : 4'd4;
      4'd4:  return b ? 4'd5  : 4'd4;
      4'd5:  return b ? 4'd8  : 4'd6;
      4'd6:  return b ? 4'd7  : 4'd6;
      4'd7:  return b ? 4'd8  : 4'd4;
      4'd8:  return b ? 4'd2  : 4'd1;
      4'd9:  return b ? 4'd0  : 4'd10;
      4'd10: return b ? 4'd12 : 4'd11;
      4'd11: return b ? 4'd12 : 4'd11;
      4'd12: return b ? 4'd15 : 4'd13;
      4'd13: return b ? 4'd14 : 4'd13;
      4'd14: return b ? 4'd15 : 4'd11;
      default: return b ? 4'd2 : 4'd1;
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [3:0] s;
    logic       b;

    do_reset();
    check(swd_mode == 1'b0, "R1 swd_mode after reset", swd_mode, 0);
    check(mode_changed == 1'b0, "R1 mode_changed after reset", mode_changed, 0);
    check(line_reset == 1'b0, "R1 line_reset after reset", line_reset, 0);
    check(tap_state == 4'd0, "R1 tap_state after reset", tap_state, 0);

    s = 4'd0;
    for (int i = 0; i < 600; i++) begin
      b = (i % 8 == 7) ? 1'b0 : rnd_bit();
      send(b);
      s = tap_next(s, b);
      check(tap_state == s, "R11 tap walk", tap_state, s);
    end
    check(swd_mode == 1'b0, "R2 short runs keep JTAG", swd_mode, 0);

    for (int len = 45; len <= 55; len++) begin
      do_reset();
      send(1'b0);
      ones(len);
      for (int i = 0; i < 16; i++) begin
        send(SWD[i]);
        if (len == 50) check(tap_state == trace[i], "R11 command trace", tap_state, trace[i]);
        if (i < 15) check(mode_changed == 1'b0, "R8 no early pulse", mode_changed, 0);
      end
      check(swd_mode == (len >= 50), "R2 R4 run length threshold", swd_mode, int'(len >= 50));
      check(mode_changed == (len >= 50), "R8 pulse on completion", mode_changed, int'(len >= 50));
      send(1'b1);
      check(mode_changed == 1'b0, "R8 pulse one cycle", mode_changed, 0);
    end

    do_reset();
    ones(30);
    send(1'b0);
    ones(30);
    word(SWD);
    check(swd_mode == 1'b0, "R3 split run does not arm", swd_mode, 0);
    ones(50);
    word(SWD);
    check(swd_mode == 1'b1, "R4 switch to serial-wire", swd_mode, 1);

    send(1'b0);
    ones(49);
    check(line_reset == 1'b0, "R9 49 highs no line reset", line_reset, 0);
    send(1'b1);
    check(line_reset == 1'b1, "R9 50 highs line reset", line_reset, 1);
    ones(1000);
    check(line_reset == 1'b1, "R10 saturated run", line_reset, 1);
    check(swd_mode == 1'b1, "R10 mode kept", swd_mode, 1);
    send(1'b0);
    check(line_reset == 1'b0, "R3 low clears line reset", line_reset, 0);

    for (int i = 0; i < 100; i++) begin
      b = (i % 8 == 7) ? 1'b0 : rnd_bit();
      send(b);
      check(tap_state == 4'd0, "R12 tap held", tap_state, 0);
    end

    ones(50);
    for (int i = 0; i < 16; i++) begin
      send(SWD[i]);
      check(mode_changed == 1'b0, "R7 same-mode no pulse", mode_changed, 0);
    end
    check(swd_mode == 1'b1, "R7 same-mode kept", swd_mode, 1);

    ones(50);
    word(JTG);
    check(swd_mode == 1'b0, "R6 switch to JTAG", swd_mode, 0);
    check(mode_changed == 1'b1, "R8 pulse on JTAG switch", mode_changed, 1);
    send(1'b0);
    ones(60);
    check(line_reset == 1'b0, "R9 no line reset in JTAG", line_reset, 0);
    check(tap_state == 4'd0, "R11 highs reach TLR", tap_state, 0);
    for (int i = 0; i < 16; i++) begin
      send(JTG[i]);
      check(mode_changed == 1'b0, "R7 JTAG same-mode no pulse", mode_changed, 0);
    end
    check(swd_mode == 1'b0, "R7 JTAG kept", swd_mode, 0);

    for (int k = 1; k < 16; k++) begin
      do_reset();
      ones(50);
      word(SWD ^ (16'h1 << k));
      check(swd_mode == 1'b0, "R5 corrupted command", swd_mode, 0);
      word(SWD);
      check(swd_mode == 1'b0, "R5 disarmed after mismatch", swd_mode, 0);
      ones(50);
      word(SWD);
      check(swd_mode == 1'b1, "R4 rearmed switch", swd_mode, 1);
    end

    finish_run();
  end
endmodule